// File: doc/BRIEF.md
# Slow-Domain Register Write Synchronizer

This block is the bus-facing front end of a small register file that lives in a 32.768 kHz low-power clock domain. A write from the fast bus is captured into a holding register. A toggle request then carries it across to the slow side, where it is applied to the target register. An acknowledge toggle comes back and closes the transaction. While a write is in flight, the block holds a busy flag. When the acknowledge lands, a write-complete flag is raised, and a bus read of the status word clears it again.

The block does not queue a second write that arrives while one is still crossing. It drops that write and raises a sticky write-error flag. Software clears the error by writing a one into its status position, and that clearing write is itself synchronized. The interrupt-enable register is the one exception to the slow path: it is written at bus speed and raises neither busy nor complete. A single interrupt line is the OR of every status flag that has its enable bit set. Two of those flags mirror alarm and violation levels that come from neighbouring logic.

The address map is as follows. Word addresses 0 to NREG-1 select the slow registers. NREG selects the status word, and NREG+1 selects the interrupt-enable word. Every other address reads as zero.

Top module: `slow_wr_bridge`

## Requirements
- R1: A write to a slow register (address below NREG) changes that register on the (SYNC_STAGES+2)-th slow-clock edge after the bus write edge and never earlier. This is the fourth slow edge with the default SYNC_STAGES=2. The busy flag (status bit 10) is high from the bus edge that accepts the write until the acknowledge returns, and a read of the register after that returns the written value.
- R2: On the bus edge where the acknowledge is detected, busy clears and write-complete (status bit 8) sets together. Write-next (status bit 9) is always the inverse of busy.
- R3: A read of the status word returns the flags as they stood before that edge and clears write-complete. If a completion lands on the same edge, the flag stays set.
- R4: A write to the interrupt-enable word (address NREG+1) takes effect on its own bus edge and keeps only bits 9, 8, 7, 4 and 0, so writing all ones reads back 0x391. It never sets busy, complete or error, and it is accepted while a synchronized write is in flight.
- R5: Any other write that arrives while busy is discarded, leaves every slow register untouched, and sets write-error (status bit 7).
- R6: Write-error stays set until a status-word write with bit 7 high completes its crossing. A status-word write with bit 7 low completes without clearing it.
- R7: The irq output is high exactly when some flag among bits 9, 8, 7, 4 and 0 is set together with its enable bit. Status bit 4 mirrors alarm_in, and status bit 0 mirrors viol_in.
- R8: After reset every slow register and the enable word are zero, the status word reads 0x200 (only write-next), and irq is low.
- R9: Read data is registered: it appears the cycle after bus_rd. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| slow_clk | input | 1 | 32.768 kHz low-power clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_addr | input | AW | Word address |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_wdata | input | DW | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW | Registered read data |
| alarm_in | input | 1 | Clock-alarm level, shown in status bit 4 |
| viol_in | input | 1 | Security-violation level, shown in status bit 0 |
| irq | output | 1 | Enabled-flag interrupt |

## Verification
The bench builds the block with its defaults: four 32-bit slow registers behind a 3-bit address, and two synchronizer stages in each direction. It runs the slow clock at 130 ns against the 20 ns bus clock. Because that ratio is not an integer, the slow-edge phase drifts from write to write, so a sweep of every register with several data words covers both the earliest and the latest acknowledge arrival. The short slow period also brings the not-before and completion windows, collision drops, error clearing, and every interrupt source within a few thousand bus cycles.

// File: rtl/slwb_pkg.sv
package slwb_pkg;
  localparam int FW       = 11;
  localparam int BIT_BUSY = 10;
  localparam int BIT_NEXT = 9;
  localparam int BIT_CMPL = 8;
  localparam int BIT_ERR  = 7;
  localparam int BIT_ALRM = 4;
  localparam int BIT_VIOL = 0;

  typedef logic [FW-1:0] flag_t;

  function automatic flag_t ie_mask();
    flag_t m;
    m = '0;
    m[BIT_NEXT] = 1'b1;
    m[BIT_CMPL] = 1'b1;
    m[BIT_ERR]  = 1'b1;
    m[BIT_ALRM] = 1'b1;
    m[BIT_VIOL] = 1'b1;
    return m;
  endfunction

  function automatic flag_t pack_status(input logic busy, input logic cmpl,
                                        input logic err, input logic alrm,
                                        input logic viol);
    flag_t s;
    s = '0;
    s[BIT_BUSY] = busy;
    s[BIT_NEXT] = ~busy;
    s[BIT_CMPL] = cmpl;
    s[BIT_ERR]  = err;
    s[BIT_ALRM] = alrm;
    s[BIT_VIOL] = viol;
    return s;
  endfunction

  function automatic flag_t ie_keep(input flag_t d);
    return d & ie_mask();
  endfunction

  function automatic logic irq_of(input flag_t st, input flag_t ie);
    return |(st & ie & ie_mask());
  endfunction
endpackage

// File: rtl/slwb_sync.sv
module slwb_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= '0;
          else        chain_q[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/slwb_slow_side.sv
module slwb_slow_side #(
  parameter int DW          = 32,
  parameter int AW          = 3,
  parameter int NREG        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     slow_clk,
  input  logic                     rst_n,
  input  logic                     req_tgl,
  input  logic [AW-1:0]            hold_addr,
  input  logic [DW-1:0]            hold_data,
  output logic                     ack_tgl,
  output logic [NREG-1:0][DW-1:0]  regs_flat
);
  logic req_s;
  logic req_q;
  logic stage_q;
  logic ack_q;
  logic new_req;
  logic [NREG-1:0][DW-1:0] regs_q;

  slwb_sync #(.STAGES(SYNC_STAGES), .W(1)) u_req_sync (
    .clk  (slow_clk),
    .rst_n(rst_n),
    .d    (req_tgl),
    .q    (req_s)
  );

  assign new_req = req_s ^ req_q;

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      stage_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      req_q   <= req_s;
      stage_q <= new_req;
      if (stage_q) ack_q <= ~ack_q;
    end
  end

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n)
          regs_q[i] <= '0;
        else if (stage_q && (hold_addr == AW'(i)))
          regs_q[i] <= hold_data;
      end
    end
  endgenerate

  assign ack_tgl   = ack_q;
  assign regs_flat = regs_q;

  AST_SINGLE_APPLY: assert property (@(posedge slow_clk) disable iff (!rst_n)
    stage_q |=> !stage_q); // R1
  AST_REGS_QUIET: assert property (@(posedge slow_clk) disable iff (!rst_n)
    !stage_q |=> $stable(regs_q)); // R1
endmodule

// File: rtl/slwb_bus_side.sv
module slwb_bus_side
  import slwb_pkg::*;
#(
  parameter int DW          = 32,
  parameter int AW          = 3,
  parameter int NREG        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     bus_clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            bus_addr,
  input  logic                     bus_wr,
  input  logic [DW-1:0]            bus_wdata,
  input  logic                     bus_rd,
  output logic [DW-1:0]            bus_rdata,
  input  logic                     alarm_in,
  input  logic                     viol_in,
  output logic                     irq,
  output logic                     req_tgl,
  output logic [AW-1:0]            hold_addr,
  output logic [DW-1:0]            hold_data,
  input  logic                     ack_tgl,
  input  logic [NREG-1:0][DW-1:0]  regs_flat
);
  localparam logic [AW-1:0] STAT_A = AW'(NREG);
  localparam logic [AW-1:0] IE_A   = AW'(NREG + 1);

  logic        pending_q, cmpl_q, err_q, req_q, ack_q;
  logic        ack_s;
  flag_t       ie_q;
  flag_t       status;
  logic [AW-1:0] haddr_q;
  logic [DW-1:0] hdata_q;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rd_mux;

  // named events for the assertions
  logic wr_ie, wr_sync, accept, collide, done, rd_stat, err_clear;

  slwb_sync #(.STAGES(SYNC_STAGES), .W(1)) u_ack_sync (
    .clk  (bus_clk),
    .rst_n(rst_n),
    .d    (ack_tgl),
    .q    (ack_s)
  );

  assign wr_ie     = bus_wr && (bus_addr == IE_A);
  assign wr_sync   = bus_wr && !wr_ie;
  assign accept    = wr_sync && !pending_q;
  assign collide   = wr_sync && pending_q;
  assign done      = ack_s ^ ack_q;
  assign rd_stat   = bus_rd && (bus_addr == STAT_A);
  assign err_clear = done && (haddr_q == STAT_A) && hdata_q[BIT_ERR];

  assign status = pack_status(pending_q, cmpl_q, err_q, alarm_in, viol_in);

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      cmpl_q    <= 1'b0;
      err_q     <= 1'b0;
      req_q     <= 1'b0;
      ack_q     <= 1'b0;
      ie_q      <= '0;
      haddr_q   <= '0;
      hdata_q   <= '0;
    end else begin
      ack_q <= ack_s;
      if (accept) begin
        pending_q <= 1'b1;
        req_q     <= ~req_q;
        haddr_q   <= bus_addr;
        hdata_q   <= bus_wdata;
      end else if (done) begin
        pending_q <= 1'b0;
      end
      if (done)         cmpl_q <= 1'b1;
      else if (rd_stat) cmpl_q <= 1'b0;
      if (collide)        err_q <= 1'b1;
      else if (err_clear) err_q <= 1'b0;
      if (wr_ie) ie_q <= ie_keep(bus_wdata[FW-1:0]);
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (bus_addr == AW'(i)) rd_mux = regs_flat[i];
    if (bus_addr == STAT_A) rd_mux = DW'(status);
    if (bus_addr == IE_A)   rd_mux = DW'(ie_q);
  end

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_of(status, ie_q);
  assign req_tgl   = req_q;
  assign hold_addr = haddr_q;
  assign hold_data = hdata_q;

  AST_ERR_NEEDS_BUSY: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(pending_q)); // R5
  AST_CMPL_NEEDS_BUSY: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $rose(cmpl_q) |-> $past(pending_q)); // R2
  AST_IE_NO_SYNC: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_ie && !pending_q) |=> !pending_q); // R4
  AST_BUSY_HOLDS: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (pending_q && !done) |=> pending_q); // R1
  AST_ERR_STICKY: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (err_q && !done) |=> err_q); // R6
  AST_DROP_KEEPS_HOLD: assert property (@(posedge bus_clk) disable iff (!rst_n)
    collide |=> ($stable(hdata_q) && $stable(haddr_q))); // R5
  AST_DONE_SETS_CMPL: assert property (@(posedge bus_clk) disable iff (!rst_n)
    done |=> (cmpl_q && !pending_q)); // R2
endmodule

// File: rtl/slow_wr_bridge.sv
module slow_wr_bridge #(
  parameter int DW          = 32,
  parameter int AW          = 3,
  parameter int NREG        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          bus_clk,
  input  logic          slow_clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  input  logic          alarm_in,
  input  logic          viol_in,
  output logic          irq
);
  logic                    req_tgl;
  logic                    ack_tgl;
  logic [AW-1:0]           hold_addr;
  logic [DW-1:0]           hold_data;
  logic [NREG-1:0][DW-1:0] regs_flat;

  initial begin
    if (DW < slwb_pkg::FW) $error("DW too narrow for the status word");
    if (NREG + 2 > (1 << AW)) $error("address space too small");
  end

  slwb_bus_side #(.DW(DW), .AW(AW), .NREG(NREG), .SYNC_STAGES(SYNC_STAGES)) u_bus (
    .bus_clk  (bus_clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .alarm_in (alarm_in),
    .viol_in  (viol_in),
    .irq      (irq),
    .req_tgl  (req_tgl),
    .hold_addr(hold_addr),
    .hold_data(hold_data),
    .ack_tgl  (ack_tgl),
    .regs_flat(regs_flat)
  );

  slwb_slow_side #(.DW(DW), .AW(AW), .NREG(NREG), .SYNC_STAGES(SYNC_STAGES)) u_slow (
    .slow_clk (slow_clk),
    .rst_n    (rst_n),
    .req_tgl  (req_tgl),
    .hold_addr(hold_addr),
    .hold_data(hold_data),
    .ack_tgl  (ack_tgl),
    .regs_flat(regs_flat)
  );
endmodule

// File: tb/slow_wr_bridge_tb_top.sv
module slow_wr_bridge_tb_top;
  localparam int DW = 32, AW = 3, NREG = 4;
  localparam int TB = 20, TS = 130;
  localparam logic [AW-1:0] STAT = AW'(NREG);
  localparam logic [AW-1:0] IEA  = AW'(NREG + 1);
  localparam int LAT_LO = (3 * TS) / TB;
  localparam int LAT_HI = (4 * TS) / TB + 6;

  logic bus_clk = 0, slow_clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0, alarm_in = 0, viol_in = 0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int checks = 0, fails = 0;
  logic [DW-1:0] model [NREG];

  always #(TB/2) bus_clk = ~bus_clk;
  initial begin #7; forever #(TS/2) slow_clk = ~slow_clk; end

  slow_wr_bridge #(.DW(DW), .AW(AW), .NREG(NREG), .SYNC_STAGES(2)) dut_i (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .alarm_in(alarm_in), .viol_in(viol_in), .irq(irq));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge bus_clk);
  endtask

  task automatic bwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge bus_clk);
    bus_wr = 0;
  endtask

  task automatic bread(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_addr = a; bus_rd = 1;
    @(negedge bus_clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic poll(output int n, output logic [DW-1:0] st);
    n = 0;
    do begin
      bread(STAT, st);
      n++;
    end while (st[10] && n < 400);
  endtask

  initial begin
    #(TB * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd, st, d;
    int n;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (5) @(negedge bus_clk);
    rst_n = 1;
    idle();

    // R8 reset state
    bread(STAT, rd); check("R8 status", rd, 32'h200);
    bread(IEA, rd);  check("R8 enables", rd, 32'h0);
    check("R8 irq", {31'b0, irq}, 32'h0);
    for (int i = 0; i < NREG; i++) begin
      bread(AW'(i), rd); check("R8 reg", rd, 32'h0);
    end

    // R1 R2 R3 sweep over registers and data words
    for (int r = 0; r < NREG; r++) begin
      for (int p = 0; p < 4; p++) begin
        d = 32'h9E3779B9 * (r * 4 + p + 1);
        bwrite(AW'(r), d);
        repeat (10) idle();
        bread(AW'(r), rd); check("R1 not before", rd, model[r]);
        poll(n, st);
        n += 11;
        check("R1 latency in window", {31'b0, (n >= LAT_LO && n <= LAT_HI)}, 32'h1);
        check("R2 complete with idle", st & 32'h700, 32'h300);
        bread(STAT, rd); check("R3 complete cleared by read", rd & 32'h100, 32'h0);
        model[r] = d;
        bread(AW'(r), rd); check("R1 readback", rd, d);
      end
    end

    // R5 collision
    bwrite(0, 32'h1111_2222);
    idle();
    bwrite(1, 32'h3333_4444);
    poll(n, st);
    check("R5 error set", st & 32'h780, 32'h380);
    model[0] = 32'h1111_2222;
    bread(1, rd); check("R5 dropped write", rd, model[1]);
    bread(0, rd); check("R1 first write kept", rd, model[0]);

    // R6 error clearing
    bwrite(STAT, 32'h0);
    poll(n, st);
    check("R6 bit7 low keeps error", st & 32'h180, 32'h180);
    bwrite(STAT, 32'h80);
    poll(n, st);
    check("R6 error cleared", st & 32'h180, 32'h100);

    // R4 enable word
    bwrite(IEA, 32'hFFFF_FFFF);
    bread(STAT, rd); check("R4 no busy", rd & 32'h580, 32'h0);
    bread(IEA, rd);  check("R4 masked enables", rd, 32'h391);
    check("R7 next irq", {31'b0, irq}, 32'h1);
    bwrite(IEA, 32'h0);
    check("R7 disabled irq", {31'b0, irq}, 32'h0);

    // R4 enable write while busy, R7 complete interrupt
    bwrite(2, 32'hCAFE_F00D);
    bwrite(IEA, 32'h100);
    repeat (40) idle();
    check("R7 complete irq", {31'b0, irq}, 32'h1);
    bread(STAT, rd); check("R4 no error from enable write", rd & 32'h580, 32'h100);
    check("R3 irq drops after read", {31'b0, irq}, 32'h0);
    model[2] = 32'hCAFE_F00D;
    bread(2, rd); check("R1 readback", rd, model[2]);

    // R7 error interrupt
    bwrite(IEA, 32'h80);
    bwrite(3, 32'h5);
    bwrite(3, 32'h6);
    check("R7 error irq", {31'b0, irq}, 32'h1);
    poll(n, st);
    model[3] = 32'h5;
    bread(3, rd); check("R5 dropped write", rd, 32'h5);
    bwrite(STAT, 32'h80);
    poll(n, st);
    check("R6 cleared irq", {31'b0, irq}, 32'h0);

    // R7 alarm and violation
    bwrite(IEA, 32'h10);
    alarm_in = 1; idle();
    check("R7 alarm irq", {31'b0, irq}, 32'h1);
    bread(STAT, rd); check("R7 alarm mirrored", rd & 32'h11, 32'h10);
    alarm_in = 0; viol_in = 1; idle();
    check("R7 violation masked", {31'b0, irq}, 32'h0);
    bwrite(IEA, 32'h1);
    check("R7 violation irq", {31'b0, irq}, 32'h1);
    viol_in = 0; idle();
    check("R7 violation gone", {31'b0, irq}, 32'h0);

    // R9 unmapped
    bread(3'd7, rd); check("R9 unmapped", rd, 32'h0);
    bread(3'd6, rd); check("R9 unmapped", rd, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule